// File: doc/BRIEF.md
# Multi-level page table walker

This block translates one virtual address at a time by walking a radix page table held in memory. A caller presents the virtual address, the kind of access (fetch, load or store), whether the access comes from user or supervisor mode, the physical page number of the root table, the number of table levels, and the two mode bits that widen access: one lets supervisor code touch user pages, and one lets loads read pages that are only executable. The walker then reads one table entry per level over a simple valid/ready read port. It follows pointer entries downward until it reaches a leaf, and then applies the leaf checks in a fixed priority.

The walker returns a single-cycle response. A successful response carries a physical page number. For a superpage leaf, the low page-number bits below the leaf's level are filled in from the virtual page number, so the result always names one base-sized page. A failing response carries the access kind of the request, so the caller can raise the matching fetch, load or store page fault, together with a cause code that names the first check that failed. The default geometry is three levels of 9-bit indices, 8-byte entries and 4 KiB pages. The walker does not update the accessed or dirty bits, and it does not apply physical protection to the entry reads.

Top module: `radix_walker`

## Requirements
- R1: `req_ready` is high only when the walker is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Each request produces exactly one single-cycle `resp_valid` pulse, after which `req_ready` is high again. `resp_access` repeats the request's access code (0 fetch, 1 load, 2 store).
- R2: Let T = 12 + 9*levels - 1. If bits 63 down to T of the virtual address are not all equal, the response is a fault with cause 1. This response comes one cycle after acceptance, and no entry is read.
- R3: The walk starts at level `req_levels`-1. At level i, the entry address is base*4096 + 8*VA[12+9i+8 : 12+9i], and the base of the first level is `req_root_ppn`. When `req_levels` is 0, the response is a fault with cause 2, one cycle after acceptance, and no entry is read.
- R4: The entry bits are V at bit 0, R at 1, W at 2, X at 3, U at 4, A at 6, D at 7, and the PPN at bits 53:10. An entry with V=1 and R=W=X=0 is a pointer: the next base is its PPN and the level drops by one. A pointer read at level 0 is a fault with cause 2.
- R5: A leaf fails with cause 3 in either of two cases. The first is U=1 while in supervisor mode, when the access is a fetch or `req_sum` is 0. The second is U=0 while in user mode.
- R6: A leaf with V=0, or with W=1 and R=0, fails with cause 4.
- R7: A leaf fails with cause 5 when it lacks the permission the access needs. A fetch needs X. A load needs R, or X while `req_mxr` is 1. A store needs both R and W.
- R8: A leaf found at level i>0 whose PPN has any of its low 9*i bits set fails with cause 6.
- R9: A leaf fails with cause 7 when A=0, or when the access is a store and D=0.
- R10: A leaf that passes every check gives `resp_fault`=0 and cause 0. Its `resp_ppn` is the leaf PPN with the low 9*i bits replaced by the same bits of VA[55:12]. On any fault, `resp_ppn` is 0.
- R11: The leaf checks are applied in the order cause 3, 4, 5, 6, 7, and only the first one that fails is reported.
- R12: At most one entry read is outstanding. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. The response comes one cycle after the `mem_rsp_valid` that returned the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 64 | Virtual address |
| req_access | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| req_root_ppn | input | 44 | Page number of the root table |
| req_levels | input | 2 | Number of table levels (0 to 3) |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Loads may read executable-only pages |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| resp_valid | output | 1 | Single-cycle result pulse |
| resp_fault | output | 1 | Translation failed |
| resp_access | output | 2 | Access kind of the finished request |
| resp_cause | output | 3 | First failing check, 0 on success |
| resp_ppn | output | 44 | Translated page number |

## Verification
A fault that needs no entry read (bad upper bits, or zero levels) is due exactly one cycle after the request is taken. Every other result is due exactly one cycle after the memory response that delivered the deciding entry. The bench tracks both events with a free-running cycle count: it records the cycle of each memory response in its memory model, and the issue cycle of each request in the driver. When the pulse appears, it compares the cycle with the right anchor. The bench samples on the falling edge and also counts entry reads per walk, comparing that count with the number of levels its own reference walk visits.

// File: rtl/walker_pkg.sv
package walker_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } access_e;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_NONCANON = 3'd1,
        CAUSE_NO_LEAF  = 3'd2,
        CAUSE_USER     = 3'd3,
        CAUSE_INVALID  = 3'd4,
        CAUSE_PERM     = 3'd5,
        CAUSE_MISALIGN = 3'd6,
        CAUSE_ACCDIRTY = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } state_e;

    // Entry flag positions, fixed by the in-memory table format
    localparam int BIT_V       = 0;
    localparam int BIT_R       = 1;
    localparam int BIT_W       = 2;
    localparam int BIT_X       = 3;
    localparam int BIT_U       = 4;
    localparam int BIT_G       = 5;
    localparam int BIT_A       = 6;
    localparam int BIT_D       = 7;
    localparam int PTE_PPN_LSB = 10;

endpackage

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
    import walker_pkg::*;
#(
    parameter int VA_W        = 64,
    parameter int PA_W        = 56,
    parameter int PPN_W       = 44,
    parameter int PAGE_SHIFT  = 12,
    parameter int IDX_W       = 9,
    parameter int LVL_W       = 2,
    parameter int ENTRY_BYTES = 8
) (
    input  logic [VA_W-1:0]  chk_vaddr,
    input  logic [LVL_W-1:0] chk_levels,
    output logic             canonical,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    int unsigned       top_bit;
    int unsigned       idx_lsb;
    logic [VA_W-1:0]   hi_mask;
    logic [VA_W-1:0]   hi_bits;
    logic [IDX_W-1:0]  idx;

    // Upper-bit agreement: everything from the top translated bit upward
    always_comb begin
        top_bit   = PAGE_SHIFT + int'(chk_levels) * IDX_W - 1;
        hi_mask   = {VA_W{1'b1}} << top_bit;
        hi_bits   = chk_vaddr & hi_mask;
        canonical = (hi_bits == '0) || (hi_bits == hi_mask);
    end

    // Entry address for the current level
    always_comb begin
        idx_lsb    = PAGE_SHIFT + int'(level) * IDX_W;
        idx        = IDX_W'(vaddr >> idx_lsb);
        entry_addr = (PA_W'(base_ppn) << PAGE_SHIFT) + (PA_W'(idx) << ENTRY_SHIFT);
    end

endmodule

// File: rtl/walk_leaf_check.sv
module walk_leaf_check
    import walker_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int PPN_W = 44,
    parameter int IDX_W = 9,
    parameter int LVL_W = 2,
    parameter int VPN_W = 52
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [LVL_W-1:0] level,
    input  access_e          access,
    input  logic             user_mode,
    input  logic             sum,
    input  logic             mxr,
    input  logic [VPN_W-1:0] vpn,
    output logic             is_pointer,
    output cause_e           cause,
    output logic [PPN_W-1:0] leaf_ppn
);
    logic             f_v, f_r, f_w, f_x, f_u, f_a, f_d;
    logic [PPN_W-1:0] ppn;
    logic [PPN_W-1:0] low_mask;
    logic             perm_ok;
    logic             ad_ok;
    logic             user_bad;
    logic             pte_unused;

    assign pte_unused = ^{pte[PTE_W-1:PTE_PPN_LSB+PPN_W], pte[PTE_PPN_LSB-1:BIT_D+1], pte[BIT_G]};

    always_comb begin
        f_v = pte[BIT_V];
        f_r = pte[BIT_R];
        f_w = pte[BIT_W];
        f_x = pte[BIT_X];
        f_u = pte[BIT_U];
        f_a = pte[BIT_A];
        f_d = pte[BIT_D];
        ppn = pte[PTE_PPN_LSB +: PPN_W];

        low_mask   = ~({PPN_W{1'b1}} << (int'(level) * IDX_W));
        is_pointer = f_v & ~f_r & ~f_w & ~f_x;

        case (access)
            ACC_FETCH: perm_ok = f_x;
            ACC_LOAD:  perm_ok = f_r | (mxr & f_x);
            default:   perm_ok = f_r & f_w;
        endcase

        ad_ok    = f_a & (f_d | (access != ACC_STORE));
        user_bad = f_u ? (~user_mode & ((access == ACC_FETCH) | ~sum)) : user_mode;

        // Fixed priority: first failing check wins
        if (user_bad)                    cause = CAUSE_USER;
        else if (~f_v | (f_w & ~f_r))    cause = CAUSE_INVALID;
        else if (~perm_ok)               cause = CAUSE_PERM;
        else if (|(ppn & low_mask))      cause = CAUSE_MISALIGN;
        else if (~ad_ok)                 cause = CAUSE_ACCDIRTY;
        else                             cause = CAUSE_NONE;

        leaf_ppn = (ppn & ~low_mask) | (PPN_W'(vpn) & low_mask);
    end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import walker_pkg::*;
#(
    parameter int VA_W        = 64,
    parameter int PPN_W       = 44,
    parameter int PAGE_SHIFT  = 12,
    parameter int IDX_W       = 9,
    parameter int LEVELS_MAX  = 3,
    parameter int ENTRY_BYTES = 8,
    parameter int PTE_W       = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic [VA_W-1:0]                    req_vaddr,
    input  logic [1:0]                         req_access,
    input  logic                               req_user,
    input  logic [PPN_W-1:0]                   req_root_ppn,
    input  logic [$clog2(LEVELS_MAX+1)-1:0]    req_levels,
    input  logic                               req_sum,
    input  logic                               req_mxr,
    output logic                               mem_req_valid,
    input  logic                               mem_req_ready,
    output logic [PPN_W+PAGE_SHIFT-1:0]        mem_req_addr,
    input  logic                               mem_rsp_valid,
    input  logic [PTE_W-1:0]                   mem_rsp_data,
    output logic                               resp_valid,
    output logic                               resp_fault,
    output logic [1:0]                         resp_access,
    output logic [2:0]                         resp_cause,
    output logic [PPN_W-1:0]                   resp_ppn
);
    localparam int LVL_W = $clog2(LEVELS_MAX + 1);
    localparam int PA_W  = PPN_W + PAGE_SHIFT;
    localparam int VPN_W = VA_W - PAGE_SHIFT;

    typedef struct packed {
        state_e             state;
        logic [VA_W-1:0]    vaddr;
        access_e            access;
        logic               user;
        logic               sum;
        logic               mxr;
        logic [LVL_W-1:0]   level;
        logic [PPN_W-1:0]   base;
        logic               fault;
        cause_e             cause;
        logic [PPN_W-1:0]   ppn;
    } walk_regs_t;

    walk_regs_t st_d, st_q;

    logic             canon_ok;
    logic [PA_W-1:0]  entry_addr;
    logic             is_ptr;
    cause_e           leaf_cause;
    logic [PPN_W-1:0] leaf_ppn;

    walk_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT),
        .IDX_W(IDX_W), .LVL_W(LVL_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_addr (
        .chk_vaddr  (req_vaddr),
        .chk_levels (req_levels),
        .canonical  (canon_ok),
        .vaddr      (st_q.vaddr),
        .base_ppn   (st_q.base),
        .level      (st_q.level),
        .entry_addr (entry_addr)
    );

    walk_leaf_check #(
        .PTE_W(PTE_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .LVL_W(LVL_W), .VPN_W(VPN_W)
    ) u_leaf (
        .pte        (mem_rsp_data),
        .level      (st_q.level),
        .access     (st_q.access),
        .user_mode  (st_q.user),
        .sum        (st_q.sum),
        .mxr        (st_q.mxr),
        .vpn        (st_q.vaddr[VA_W-1:PAGE_SHIFT]),
        .is_pointer (is_ptr),
        .cause      (leaf_cause),
        .leaf_ppn   (leaf_ppn)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.vaddr  = req_vaddr;
                    st_d.access = access_e'(req_access);
                    st_d.user   = req_user;
                    st_d.sum    = req_sum;
                    st_d.mxr    = req_mxr;
                    st_d.base   = req_root_ppn;
                    st_d.level  = req_levels - LVL_W'(1);
                    st_d.fault  = 1'b0;
                    st_d.cause  = CAUSE_NONE;
                    st_d.ppn    = '0;
                    if (req_levels == '0) begin
                        st_d.fault = 1'b1;
                        st_d.cause = CAUSE_NO_LEAF;
                        st_d.state = ST_DONE;
                    end else if (!canon_ok) begin
                        st_d.fault = 1'b1;
                        st_d.cause = CAUSE_NONCANON;
                        st_d.state = ST_DONE;
                    end else begin
                        st_d.state = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (mem_req_ready) st_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (is_ptr) begin
                        if (st_q.level == '0) begin
                            st_d.fault = 1'b1;
                            st_d.cause = CAUSE_NO_LEAF;
                            st_d.state = ST_DONE;
                        end else begin
                            st_d.level = st_q.level - LVL_W'(1);
                            st_d.base  = mem_rsp_data[PTE_PPN_LSB +: PPN_W];
                            st_d.state = ST_SEND;
                        end
                    end else if (leaf_cause != CAUSE_NONE) begin
                        st_d.fault = 1'b1;
                        st_d.cause = leaf_cause;
                        st_d.state = ST_DONE;
                    end else begin
                        st_d.ppn   = leaf_ppn;
                        st_d.state = ST_DONE;
                    end
                end
            end
            ST_DONE: st_d.state = ST_IDLE;
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready     = (st_q.state == ST_IDLE);
    assign mem_req_valid = (st_q.state == ST_SEND);
    assign mem_req_addr  = entry_addr;
    assign resp_valid    = (st_q.state == ST_DONE);
    assign resp_fault    = st_q.fault;
    assign resp_access   = st_q.access;
    assign resp_cause    = st_q.cause;
    assign resp_ppn      = st_q.ppn;

    // R1: one-cycle result pulse, then ready for the next request
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid && req_ready);

    // R2: bad upper bits answered on the next cycle
    p_noncanon_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_levels != '0) && !canon_ok
        |=> resp_valid && resp_fault && (resp_cause == CAUSE_NONCANON));

    // R4: a pointer above level 0 leads to another entry read
    p_pointer_descend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_WAIT) && mem_rsp_valid && is_ptr && (st_q.level != '0)
        |=> mem_req_valid);

    // R10: faults carry no page number
    p_fault_ppn_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault |-> resp_ppn == '0);

    // R12: read request held until accepted
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

endmodule

// File: tb/tb_radix_walker.sv
`timescale 1ns/1ps
module tb_radix_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        req_user = 1'b0;
    logic [43:0] req_root_ppn = '0;
    logic [1:0]  req_levels = '0;
    logic        req_sum = 1'b0;
    logic        req_mxr = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        resp_valid;
    logic        resp_fault;
    logic [1:0]  resp_access;
    logic [2:0]  resp_cause;
    logic [43:0] resp_ppn;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_rsp = 0;
    int rd_count = 0;

    always #2 clk = ~clk;

    radix_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_access(req_access), .req_user(req_user), .req_root_ppn(req_root_ppn),
        .req_levels(req_levels), .req_sum(req_sum), .req_mxr(req_mxr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_access(resp_access), .resp_cause(resp_cause), .resp_ppn(resp_ppn)
    );

    logic [63:0] pt_mem [logic [55:0]];

    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FA = 8'h40, FD = 8'h80;

    function automatic logic [63:0] rd_mem(input logic [55:0] a);
        return pt_mem.exists(a) ? pt_mem[a] : 64'd0;
    endfunction

    function automatic logic [55:0] ent_addr(input logic [43:0] base, input logic [63:0] va, input int lvl);
        logic [8:0] idx;
        idx = va[12 + 9*lvl +: 9];
        return {base, 12'd0} + {44'd0, idx, 3'd0};
    endfunction

    function automatic logic [63:0] mk_leaf(input logic [43:0] ppn, input logic [7:0] fl);
        return {10'd0, ppn, 2'd0, fl};
    endfunction

    function automatic logic [63:0] mk_ptr(input logic [43:0] ppn);
        return {10'd0, ppn, 2'd0, FV};
    endfunction

    // Reference walk built from the requirements
    function automatic void ref_walk(input logic [63:0] va, input logic [1:0] acc,
                                     input logic um, input logic su, input logic mx,
                                     input logic [43:0] root, input int lv,
                                     output logic flt, output logic [2:0] cs,
                                     output logic [43:0] pp, output int nrd);
        logic [63:0] hm, hb, pte;
        logic [43:0] base, ppn, lm;
        logic        pok;
        flt = 1'b1; cs = 3'd2; pp = '0; nrd = 0;
        if (lv == 0) return;
        hm = {64{1'b1}} << (12 + 9*lv - 1);
        hb = va & hm;
        if (!(hb == 64'd0 || hb == hm)) begin cs = 3'd1; return; end
        base = root;
        for (int l = lv - 1; l >= 0; l--) begin
            pte = rd_mem(ent_addr(base, va, l));
            nrd++;
            ppn = pte[53:10];
            if (pte[0] && pte[3:1] == 3'b000) begin
                if (l == 0) begin cs = 3'd2; return; end
                base = ppn;
                continue;
            end
            lm  = ~({44{1'b1}} << (9*l));
            pok = (acc == 2'd0) ? pte[3] : (acc == 2'd1) ? (pte[1] || (mx && pte[3])) : (pte[1] && pte[2]);
            if (pte[4] ? (!um && (acc == 2'd0 || !su)) : um)      cs = 3'd3;
            else if (!pte[0] || (pte[2] && !pte[1]))               cs = 3'd4;
            else if (!pok)                                         cs = 3'd5;
            else if ((ppn & lm) != 44'd0)                          cs = 3'd6;
            else if (!pte[6] || (acc == 2'd2 && !pte[7]))          cs = 3'd7;
            else begin
                flt = 1'b0; cs = 3'd0;
                pp  = (ppn & ~lm) | (va[55:12] & lm);
            end
            return;
        end
    endfunction

    // Memory model: random accept stall, 1..3 cycle read latency
    logic        pend = 1'b0;
    logic [55:0] p_addr = '0;
    int          dly = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            pend <= 1'b0;
            mem_req_ready <= 1'b0;
            mem_rsp_data <= '0;
        end else begin
            mem_req_ready <= ($urandom % 4) != 0;
            if (mem_rsp_valid) last_rsp <= cyc;
            if (mem_req_valid && mem_req_ready) begin
                pend <= 1'b1;
                p_addr <= mem_req_addr;
                dly <= $urandom % 3;
                rd_count <= rd_count + 1;
            end else if (pend) begin
                if (dly == 0) begin
                    pend <= 1'b0;
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data <= rd_mem(p_addr);
                end else begin
                    dly <= dly - 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string cause_tag(input logic [2:0] c, input int lv);
        case (c)
            3'd0: return "R10";
            3'd1: return "R2";
            3'd2: return (lv == 0) ? "R3" : "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic run(input string nm, input logic [63:0] va, input logic [1:0] acc,
                       input logic um, input logic su, input logic mx,
                       input logic [43:0] root, input int lv);
        logic        eflt;
        logic [2:0]  ecs;
        logic [43:0] epp;
        int          enr, rd0, st, wd;
        string       tg;
        ref_walk(va, acc, um, su, mx, root, lv, eflt, ecs, epp, enr);
        tg = cause_tag(ecs, lv);
        @(negedge clk);
        rd0 = rd_count;
        st  = cyc;
        req_valid = 1'b1; req_vaddr = va; req_access = acc; req_user = um;
        req_sum = su; req_mxr = mx; req_root_ppn = root; req_levels = 2'(lv);
        @(negedge clk);
        req_valid = 1'b0;
        wd = 0;
        while (!resp_valid && wd < 500) begin
            @(negedge clk);
            wd++;
        end
        if (!resp_valid) begin
            tests++; fails++;
            $display("FAIL R1 %s: no response, actual 0 expected 1", nm);
            return;
        end
        chk({nm, " ", tg, " fault flag"}, 64'(resp_fault), 64'(eflt));
        chk({nm, " ", tg, " cause (R11 order)"}, 64'(resp_cause), 64'(ecs));
        chk({nm, " R10 ppn"}, 64'(resp_ppn), 64'(epp));
        chk({nm, " R1 access echo"}, 64'(resp_access), 64'(acc));
        chk({nm, " R3 entry reads"}, 64'(rd_count - rd0), 64'(enr));
        if (enr == 0) chk({nm, " R2 latency"}, 64'(cyc - st), 64'd1);
        else          chk({nm, " R12 latency"}, 64'(cyc - last_rsp), 64'd1);
        @(negedge clk);
        chk({nm, " R1 pulse ends"}, 64'({resp_valid, req_ready}), 64'b01);
    endtask

    initial begin
        #(200000 * 4);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] va, hm;
        logic [43:0] base, np, pp;
        logic [7:0]  fl;
        int          lv, tb_bit;
        void'($urandom(32'd51734));

        repeat (4) @(negedge clk);
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R1 reset no resp", 64'(resp_valid), 64'd0);
        chk("R12 reset no read", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // Directed: 3-level walk to a 4 KiB page, store
        va = 64'h0000_0012_3456_7ABC;
        pt_mem.delete();
        pt_mem[ent_addr(44'h100, va, 2)] = mk_ptr(44'h200);
        pt_mem[ent_addr(44'h200, va, 1)] = mk_ptr(44'h300);
        pt_mem[ent_addr(44'h300, va, 0)] = mk_leaf(44'hABCDE, FV|FR|FW|FA|FD);
        run("base page", va, 2'd2, 1'b0, 1'b0, 1'b0, 44'h100, 3);
        // Same table, store entry now lacks D
        pt_mem[ent_addr(44'h300, va, 0)] = mk_leaf(44'hABCDE, FV|FR|FW|FA);
        run("store no D", va, 2'd2, 1'b0, 1'b0, 1'b0, 44'h100, 3);
        run("load no D ok", va, 2'd1, 1'b0, 1'b0, 1'b0, 44'h100, 3);

        // Giga superpage fill-in and misalignment
        pt_mem.delete();
        pt_mem[ent_addr(44'h100, va, 2)] = mk_leaf(44'h40000, FV|FX|FA);
        run("giga fetch", va, 2'd0, 1'b0, 1'b0, 1'b0, 44'h100, 3);
        pt_mem[ent_addr(44'h100, va, 2)] = mk_leaf(44'h40001, FV|FX|FA);
        run("giga misaligned", va, 2'd0, 1'b0, 1'b0, 1'b0, 44'h100, 3);
        pt_mem[ent_addr(44'h100, va, 2)] = mk_leaf(44'h40001, FV|FX);
        run("misalign before A", va, 2'd0, 1'b0, 1'b0, 1'b0, 44'h100, 3);

        // Upper-bit agreement and level count edges
        run("noncanonical", 64'h8000_0000_0000_1000, 2'd1, 1'b0, 1'b0, 1'b0, 44'h100, 3);
        run("noncanon 1 lvl", 64'h0000_0000_0010_0000, 2'd1, 1'b0, 1'b0, 1'b0, 44'h100, 1);
        run("zero levels", 64'h0, 2'd0, 1'b0, 1'b0, 1'b0, 44'h100, 0);
        pt_mem.delete();
        pt_mem[ent_addr(44'h100, 64'h5000, 0)] = mk_ptr(44'h777);
        run("pointer at 0", 64'h5000, 2'd1, 1'b0, 1'b0, 1'b0, 44'h100, 1);

        // User bit, SUM, MXR, reserved encodings, check order
        va = 64'h7000;
        pt_mem.delete();
        pt_mem[ent_addr(44'h100, va, 0)] = mk_leaf(44'h123, FV|FR|FX|FU|FA);
        run("sum load ok", va, 2'd1, 1'b0, 1'b1, 1'b0, 44'h100, 1);
        run("no sum load", va, 2'd1, 1'b0, 1'b0, 1'b0, 44'h100, 1);
        run("sum fetch", va, 2'd0, 1'b0, 1'b1, 1'b0, 44'h100, 1);
        run("user fetch ok", va, 2'd0, 1'b1, 1'b0, 1'b0, 44'h100, 1);
        pt_mem[ent_addr(44'h100, va, 0)] = mk_leaf(44'h123, FV|FX|FA);
        run("xonly load", va, 2'd1, 1'b0, 1'b0, 1'b0, 44'h100, 1);
        run("mxr load ok", va, 2'd1, 1'b0, 1'b0, 1'b1, 44'h100, 1);
        run("user on sup", va, 2'd0, 1'b1, 1'b0, 1'b0, 44'h100, 1);
        pt_mem[ent_addr(44'h100, va, 0)] = mk_leaf(44'h123, FV|FW|FD);
        run("W no R", va, 2'd2, 1'b0, 1'b0, 1'b0, 44'h100, 1);
        run("absent entry", 64'h9000, 2'd1, 1'b0, 1'b0, 1'b0, 44'h100, 1);
        run("absent user", 64'h9000, 2'd1, 1'b1, 1'b0, 1'b0, 44'h100, 1);

        // Random walks
        for (int n = 0; n < 300; n++) begin
            pt_mem.delete();
            base = 44'($urandom_range(0, 32'hFFFFF));
            np = base;
            lv = $urandom_range(1, 3);
            va = {$urandom, $urandom};
            if ($urandom % 10 != 0) begin
                tb_bit = 12 + 9*lv - 1;
                hm = {64{1'b1}} << tb_bit;
                va = va[tb_bit] ? (va | hm) : (va & ~hm);
            end
            for (int l = lv - 1; l >= 0; l--) begin
                if ((l > 0 && $urandom % 3 == 0) || (l == 0 && $urandom % 10 == 0)) begin
                    pp = 44'($urandom_range(0, 32'hFFFFF));
                    pt_mem[ent_addr(base, va, l)] = mk_ptr(pp);
                    base = pp;
                end else begin
                    fl = 8'($urandom);
                    fl[0] = ($urandom % 10) != 0;
                    fl[6] = ($urandom % 5) != 0;
                    fl[7] = ($urandom % 4) != 0;
                    if (fl[3:1] == 3'b000) fl[1] = 1'b1;
                    pp = 44'({$urandom, $urandom});
                    if ($urandom % 2 == 0) pp = pp & ({44{1'b1}} << (9*l));
                    pt_mem[ent_addr(base, va, l)] = mk_leaf(pp, fl);
                    break;
                end
            end
            run($sformatf("rand%0d", n), va, 2'($urandom % 3), 1'($urandom), 1'($urandom),
                1'($urandom), np, lv);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule